// File: doc/BRIEF.md
# Flash Read SECDED Checker with Error Address Capture

This block sits on the read path of a flash array. Each read returns a unit of several 32-bit words, two by default, and every word carries its own seven check bits. The block decodes all words of the unit in parallel. It repairs any single flipped bit in a word and recognises any two flipped bits. It then passes the one word picked by the read address back to the bus one cycle later.

Integrity is checked over the whole fetched unit, not only over the word the bus asked for. A fault in the neighbouring word therefore shows up in the status even when the returned word is clean. The sticky status keeps the worst outcome seen since the last clear. An error-address register records the bus address of a failing read. How that register behaves depends on the interrupt enable. When the enable is set, the first failure is kept and an interrupt is raised. When the enable is clear, every failure overwrites the register and no interrupt is raised. A write-one-to-clear pulse resets the status, the interrupt and the first-failure lock.

Top module: `flash_ecc_checker`

## Requirements
- R1: Each word in `rd_raw_i` occupies 39 bits, with word k at bits [39k+38:39k]. Within a word, bits [31:0] are data. Bit 32+i is the Hamming check bit for every codeword position (1..38) whose index has bit i set, with data bits filling the non-power-of-two positions 3,5,6,7,9,... in ascending order. Bit 38 makes the XOR of all 39 bits zero.
- R2: A single flipped data bit in a word is corrected in the returned data, and that word is reported as 01.
- R3: A single flipped check bit or overall parity bit leaves the returned data equal to the original data, and the word is reported as 01.
- R4: Two flipped bits in one word are reported as 10, and the data bits are returned as received, without modification.
- R5: The returned word is the one selected by `rd_addr_i[2]`. An error in the other word of the unit still updates the status, the interrupt and the address capture.
- R6: Status encoding is 00 clean, 01 corrected, 10 uncorrectable, and 11 never appears. The status holds the worst outcome of all words read since the last clear or reset.
- R7: `ecc_irq_o` sets on an erroneous read only while `irq_en_i` is 1, and stays set until cleared.
- R8: While `irq_en_i` is 1, only the first error after a clear or reset loads `err_addr_o`. Later errors leave it unchanged.
- R9: While `irq_en_i` is 0, every erroneous read loads its `rd_addr_i` into `err_addr_o`.
- R10: A `clr_i` pulse resets the status, the interrupt and the first-error lock, and keeps `err_addr_o`. A read in the same cycle is applied after the clear.
- R11: `rd_valid_o` and `rd_data_o` follow an accepted read by exactly one cycle. The status, interrupt and address register update at that same edge.
- R12: After reset, all outputs are zero.
- R13: When the overall parity fails but the syndrome points past position 38, the word is reported as uncorrectable (10) and its data is not altered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid_i | input | 1 | Read data and address are valid this cycle |
| rd_addr_i | input | 32 | Byte address of the read on the bus |
| rd_raw_i | input | 78 | Fetched unit: two 39-bit codewords |
| irq_en_i | input | 1 | ECC interrupt enable; also selects the capture policy |
| clr_i | input | 1 | Write-one-to-clear pulse for status, interrupt and lock |
| rd_valid_o | output | 1 | Returned word is valid |
| rd_data_o | output | 32 | Corrected addressed word |
| ecc_status_o | output | 2 | Sticky worst ECC outcome |
| err_addr_o | output | 32 | Captured failing address |
| ecc_irq_o | output | 1 | Sticky ECC interrupt |

## Verification
The bench flips every single data bit and every check bit. A decoder with a wrong position map would return corrupted data or a wrong status here. It also plants faults only in the word that is not addressed. A design that checked only the returned half would report a clean status there. The bench crafts a seven-bit fault pattern whose syndrome points past the end of the code, which a naive decoder would "correct" into garbage. It also toggles the interrupt enable across repeated errors, with clears landing alone and together with a read, to expose a capture lock that is ignored, never released, or applied in the wrong order.

// File: rtl/flash_ecc_pkg.sv
package flash_ecc_pkg;

   typedef enum logic [1:0] {
      ECC_OK    = 2'b00,
      ECC_FIXED = 2'b01,
      ECC_FATAL = 2'b10
   } ecc_stat_e;

   // number of Hamming check bits needed for a data word of width w
   function automatic int hamming_bits(input int w);
      int p;
      p = 1;
      while ((1 << p) < (w + p + 1)) p++;
      return p;
   endfunction

   // 1-based codeword position of data bit j (skips powers of two)
   function automatic int data_pos(input int j);
      int pos;
      int seen;
      pos  = 1;
      seen = -1;
      while (seen < j) begin
         pos++;
         if ((pos & (pos - 1)) != 0) seen++;
      end
      return pos;
   endfunction

   // status codes are ordered by severity
   function automatic ecc_stat_e worse(input ecc_stat_e a, input ecc_stat_e b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/secded_dec.sv
module secded_dec
   import flash_ecc_pkg::*;
#(
   parameter int  WORD_W = 32,
   localparam int P_W    = hamming_bits(WORD_W),
   localparam int CW_W   = WORD_W + P_W + 1
) (
   input  logic [CW_W-1:0]   cw_i,
   output logic [WORD_W-1:0] data_o,
   output ecc_stat_e         stat_o
);

   localparam int            LAST_POS = WORD_W + P_W;
   localparam logic [P_W-1:0] LAST_L  = P_W'(LAST_POS);

   logic [P_W-1:0] syn;
   logic           par_bad;
   logic           in_range;

   // syndrome: recomputed check bits against the stored ones
   always_comb begin
      for (int i = 0; i < P_W; i++) begin
         syn[i] = cw_i[WORD_W + i];
         for (int j = 0; j < WORD_W; j++) begin
            if (((data_pos(j) >> i) & 1) != 0) syn[i] = syn[i] ^ cw_i[j];
         end
      end
   end

   assign par_bad  = ^cw_i;
   assign in_range = (syn <= LAST_L);

   // flip the data bit named by the syndrome when exactly one bit is wrong
   always_comb begin
      data_o = cw_i[WORD_W-1:0];
      if (par_bad && in_range && (syn != '0)) begin
         for (int j = 0; j < WORD_W; j++) begin
            if (syn == P_W'(data_pos(j))) data_o[j] = ~cw_i[j];
         end
      end
   end

   always_comb begin
      if (!par_bad && (syn == '0))  stat_o = ECC_OK;
      else if (par_bad && in_range) stat_o = ECC_FIXED;
      else                          stat_o = ECC_FATAL;
   end

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
   import flash_ecc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid_i,
   input  ecc_stat_e         ev_stat_i,
   input  logic [ADDR_W-1:0] ev_addr_i,
   input  logic              irq_en_i,
   input  logic              clr_i,
   output ecc_stat_e         stat_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              irq_o
);

   logic              locked_q;
   ecc_stat_e         base_stat;
   logic              base_irq;
   logic              base_lock;
   logic              is_err;
   logic              take;
   ecc_stat_e         nxt_stat;
   logic              nxt_irq;
   logic              nxt_lock;
   logic [ADDR_W-1:0] nxt_addr;

   // clear first, then fold in the read of the same cycle
   always_comb begin
      base_stat = clr_i ? ECC_OK : stat_o;
      base_irq  = clr_i ? 1'b0   : irq_o;
      base_lock = clr_i ? 1'b0   : locked_q;
      is_err    = ev_valid_i && (ev_stat_i != ECC_OK);
      nxt_stat  = ev_valid_i ? worse(base_stat, ev_stat_i) : base_stat;
      nxt_irq   = base_irq  | (is_err & irq_en_i);
      nxt_lock  = base_lock | (is_err & irq_en_i);
      take      = is_err && !(irq_en_i && base_lock);
      nxt_addr  = take ? ev_addr_i : addr_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_o   <= ECC_OK;
         irq_o    <= 1'b0;
         locked_q <= 1'b0;
         addr_o   <= '0;
      end else begin
         stat_o   <= nxt_stat;
         irq_o    <= nxt_irq;
         locked_q <= nxt_lock;
         addr_o   <= nxt_addr;
      end
   end

endmodule

// File: rtl/flash_ecc_checker.sv
module flash_ecc_checker
   import flash_ecc_pkg::*;
#(
   parameter int  WORD_W    = 32,
   parameter int  NUM_WORDS = 2,
   parameter int  ADDR_W    = 32,
   localparam int P_W       = hamming_bits(WORD_W),
   localparam int CW_W      = WORD_W + P_W + 1,
   localparam int RAW_W     = NUM_WORDS * CW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_valid_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic [RAW_W-1:0]  rd_raw_i,
   input  logic              irq_en_i,
   input  logic              clr_i,
   output logic              rd_valid_o,
   output logic [WORD_W-1:0] rd_data_o,
   output logic [1:0]        ecc_status_o,
   output logic [ADDR_W-1:0] err_addr_o,
   output logic              ecc_irq_o
);

   localparam int LANE_LSB = $clog2(WORD_W / 8);
   localparam int SEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

   // elaboration-time parameter checks
   if ((WORD_W % 8) != 0 || WORD_W < 8) begin : g_bad_word
      $error("WORD_W must be a multiple of 8 and at least 8");
   end
   if (NUM_WORDS < 1 || (NUM_WORDS & (NUM_WORDS - 1)) != 0) begin : g_bad_num
      $error("NUM_WORDS must be a power of two");
   end
   if (ADDR_W <= LANE_LSB + SEL_W) begin : g_bad_addr
      $error("ADDR_W too small for word select");
   end

   logic [WORD_W-1:0] dec_data [NUM_WORDS];
   ecc_stat_e         dec_stat [NUM_WORDS];
   ecc_stat_e         unit_stat;
   ecc_stat_e         cap_stat;
   logic [SEL_W-1:0]  word_sel;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      secded_dec #(.WORD_W(WORD_W)) u_dec (
         .cw_i   (rd_raw_i[w*CW_W +: CW_W]),
         .data_o (dec_data[w]),
         .stat_o (dec_stat[w])
      );
   end

   // worst outcome across every word of the fetched unit
   always_comb begin
      unit_stat = ECC_OK;
      for (int w = 0; w < NUM_WORDS; w++) unit_stat = worse(unit_stat, dec_stat[w]);
   end

   if (NUM_WORDS == 1) begin : g_sel_single
      assign word_sel = '0;
   end else begin : g_sel_multi
      assign word_sel = rd_addr_i[LANE_LSB +: SEL_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= rd_valid_i;
         if (rd_valid_i) rd_data_o <= dec_data[word_sel];
      end
   end

   ecc_err_capture #(.ADDR_W(ADDR_W)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_valid_i (rd_valid_i),
      .ev_stat_i  (unit_stat),
      .ev_addr_i  (rd_addr_i),
      .irq_en_i   (irq_en_i),
      .clr_i      (clr_i),
      .stat_o     (cap_stat),
      .addr_o     (err_addr_o),
      .irq_o      (ecc_irq_o)
   );

   assign ecc_status_o = cap_stat;

endmodule

// File: rtl/flash_ecc_checker_sva.sv
module flash_ecc_checker_sva #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_valid_i,
   input logic              irq_en_i,
   input logic              clr_i,
   input logic              rd_valid_o,
   input logic [1:0]        ecc_status_o,
   input logic [ADDR_W-1:0] err_addr_o,
   input logic              ecc_irq_o
);

   assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_i |=> rd_valid_o);

   assert_idle_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid_i |=> !rd_valid_o);

   assert_no_code11_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_status_o != 2'b11);

   assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (ecc_status_o >= $past(ecc_status_o)));

   assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ecc_irq_o) |-> $past(irq_en_i && rd_valid_i));

   assert_clear_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !rd_valid_i) |=> (ecc_status_o == 2'b00 && !ecc_irq_o));

   assert_first_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_i && ecc_irq_o && !clr_i) |=> $stable(err_addr_o));

endmodule

bind flash_ecc_checker flash_ecc_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_valid_i   (rd_valid_i),
   .irq_en_i     (irq_en_i),
   .clr_i        (clr_i),
   .rd_valid_o   (rd_valid_o),
   .ecc_status_o (ecc_status_o),
   .err_addr_o   (err_addr_o),
   .ecc_irq_o    (ecc_irq_o)
);

// File: tb/flash_ecc_checker_bench.sv
`timescale 1ns/1ps
module flash_ecc_checker_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_valid_i = 1'b0;
   logic [31:0] rd_addr_i = '0;
   logic [77:0] rd_raw_i = '0;
   logic        irq_en_i = 1'b0;
   logic        clr_i = 1'b0;
   logic        rd_valid_o;
   logic [31:0] rd_data_o;
   logic [1:0]  ecc_status_o;
   logic [31:0] err_addr_o;
   logic        ecc_irq_o;

   int n_tot = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // model state
   logic [1:0]  m_stat = 2'b00;
   logic        m_irq = 1'b0;
   logic        m_lock = 1'b0;
   logic [31:0] m_addr = '0;

   always #2 clk = ~clk;

   flash_ecc_checker u_flash_ecc_checker (
      .clk(clk), .rst_n(rst_n), .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i),
      .rd_raw_i(rd_raw_i), .irq_en_i(irq_en_i), .clr_i(clr_i),
      .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .ecc_status_o(ecc_status_o),
      .err_addr_o(err_addr_o), .ecc_irq_o(ecc_irq_o)
   );

   function automatic logic [38:0] enc(input logic [31:0] d);
      logic [38:0] cw;
      logic [5:0]  p;
      int pos;
      int j;
      p = '0;
      j = 0;
      for (int q = 1; q <= 38; q++) begin
         if ((q & (q - 1)) != 0) begin
            pos = q;
            for (int i = 0; i < 6; i++) if (((pos >> i) & 1) != 0) p[i] = p[i] ^ d[j];
            j++;
         end
      end
      cw = {1'b0, p, d};
      cw[38] = ^cw[37:0];
      return cw;
   endfunction

   function automatic logic [38:0] rand_mask(input int n);
      logic [38:0] m;
      int k;
      int b;
      m = '0;
      k = 0;
      while (k < n) begin
         b = int'($urandom % 39);
         if (!m[b]) begin
            m[b] = 1'b1;
            k++;
         end
      end
      return m;
   endfunction

   function automatic logic [1:0] word_stat(input logic [38:0] m);
      int c;
      c = $countones(m);
      if (c == 0) return 2'b00;
      if (c == 1) return 2'b01;
      return 2'b10;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_tot++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_regs(input string req);
      check(ecc_status_o == m_stat, req, "status", 64'(ecc_status_o), 64'(m_stat));
      check(ecc_irq_o == m_irq, req, "irq", 64'(ecc_irq_o), 64'(m_irq));
      check(err_addr_o == m_addr, req, "err_addr", 64'(err_addr_o), 64'(m_addr));
   endtask

   task automatic run_read(input logic [31:0] d0, input logic [31:0] d1,
                           input logic [38:0] m0, input logic [38:0] m1,
                           input logic [31:0] addr, input logic en, input logic clr,
                           input string req);
      logic [1:0]  s0;
      logic [1:0]  s1;
      logic [1:0]  ev;
      logic [31:0] exp_d;
      logic [38:0] msel;
      logic [31:0] dsel;
      bit          err;
      bit          take;
      @(negedge clk);
      rd_raw_i   = {enc(d1) ^ m1, enc(d0) ^ m0};
      rd_addr_i  = addr;
      irq_en_i   = en;
      clr_i      = clr;
      rd_valid_i = 1'b1;
      @(posedge clk);
      #1;
      s0 = word_stat(m0);
      s1 = word_stat(m1);
      ev = (s0 > s1) ? s0 : s1;
      if (clr) begin
         m_stat = 2'b00;
         m_irq  = 1'b0;
         m_lock = 1'b0;
      end
      if (ev > m_stat) m_stat = ev;
      err  = (ev != 2'b00);
      take = err && !(en && m_lock);
      if (err && en) begin
         m_irq  = 1'b1;
         m_lock = 1'b1;
      end
      if (take) m_addr = addr;
      msel  = addr[2] ? m1 : m0;
      dsel  = addr[2] ? d1 : d0;
      exp_d = ($countones(msel) <= 1) ? dsel : (dsel ^ msel[31:0]);
      check(rd_valid_o == 1'b1, req, "rd_valid", 64'(rd_valid_o), 64'd1);
      check(rd_data_o == exp_d, req, "rd_data", 64'(rd_data_o), 64'(exp_d));
      check_regs(req);
      rd_valid_i = 1'b0;
      clr_i      = 1'b0;
   endtask

   task automatic do_clear(input string req);
      @(negedge clk);
      clr_i = 1'b1;
      rd_valid_i = 1'b0;
      @(posedge clk);
      #1;
      m_stat = 2'b00;
      m_irq  = 1'b0;
      m_lock = 1'b0;
      check_regs(req);
      clr_i = 1'b0;
   endtask

   task automatic idle_check(input string req);
      @(posedge clk);
      #1;
      check(rd_valid_o == 1'b0, req, "idle rd_valid", 64'(rd_valid_o), 64'd0);
      check_regs(req);
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_tot++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
         $finish;
      end
   end

   initial begin
      logic [38:0] m;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      #1;
      // R12: reset state
      check(rd_valid_o == 1'b0, "R12", "rd_valid", 64'(rd_valid_o), 64'd0);
      check(rd_data_o == '0, "R12", "rd_data", 64'(rd_data_o), 64'd0);
      check_regs("R12");
      @(negedge clk);
      rst_n = 1'b1;

      // R1 / R11: clean reads, both halves
      run_read(32'hDEADBEEF, 32'h01234567, '0, '0, 32'h0000_1000, 1'b0, 1'b0, "R1");
      run_read(32'hDEADBEEF, 32'h01234567, '0, '0, 32'h0000_1004, 1'b0, 1'b0, "R11");
      idle_check("R11");

      // R2: every data bit flipped in turn, in the addressed word
      for (int b = 0; b < 32; b++) begin
         m = '0;
         m[b] = 1'b1;
         run_read(32'hA5A5_0F0F ^ (32'h1 << b), 32'h5555_AAAA, m, '0,
                  32'h2000 + 32'(b * 8), 1'b0, 1'b1, "R2");
      end
      // R3: each check bit and the overall parity bit
      for (int b = 32; b < 39; b++) begin
         m = '0;
         m[b] = 1'b1;
         run_read(32'h1357_9BDF, 32'hFFFF_0000, '0, m, 32'h3004, 1'b0, 1'b1, "R3");
      end
      // R4: double error in addressed word
      run_read(32'hCAFE_F00D, 32'h0, 39'h0_0000_0201, '0, 32'h4000, 1'b0, 1'b1, "R4");
      run_read(32'h0, 32'h8765_4321, '0, 39'h40_8000_0000, 32'h4004, 1'b0, 1'b1, "R4");
      // R5: error only in the non-addressed word
      run_read(32'h1111_2222, 32'h3333_4444, '0, 39'h0_0000_0010, 32'h5000, 1'b0, 1'b1, "R5");
      run_read(32'h1111_2222, 32'h3333_4444, 39'h0_0010_0001, '0, 32'h5004, 1'b0, 1'b1, "R5");
      // R13: all six Hamming bits plus parity bit flipped -> syndrome 63
      run_read(32'h0BAD_CAFE, 32'h0, 39'h7F_0000_0000, '0, 32'h6000, 1'b0, 1'b1, "R13");
      // R6: stickiness: fatal then clean keeps 10, then single keeps 10
      run_read(32'h1, 32'h2, '0, '0, 32'h6008, 1'b0, 1'b0, "R6");
      run_read(32'h1, 32'h2, 39'h1, '0, 32'h600C, 1'b0, 1'b0, "R6");
      // R10: clear alone
      do_clear("R10");
      // R9: enable low -> no irq, every error captured
      run_read(32'h9, 32'h9, 39'h4, '0, 32'h7000, 1'b0, 1'b0, "R9");
      run_read(32'h9, 32'h9, '0, 39'h8, 32'h7004, 1'b0, 1'b0, "R9");
      run_read(32'h9, 32'h9, '0, '0, 32'h7008, 1'b0, 1'b0, "R7");
      // R8: enable high -> first error kept, irq set
      run_read(32'h7, 32'h8, 39'h100, '0, 32'h8000, 1'b1, 1'b0, "R7");
      run_read(32'h7, 32'h8, 39'h3, '0, 32'h8004, 1'b1, 1'b0, "R8");
      run_read(32'h7, 32'h8, '0, 39'h1, 32'h8008, 1'b1, 1'b0, "R8");
      // R10: clear in same cycle as an erroneous read -> new capture
      run_read(32'h7, 32'h8, '0, 39'h2, 32'h800C, 1'b1, 1'b1, "R10");
      run_read(32'h7, 32'h8, '0, 39'h2, 32'h8010, 1'b1, 1'b0, "R8");
      do_clear("R10");
      idle_check("R10");

      // random mix
      for (int k = 0; k < 400; k++) begin
         run_read($urandom, $urandom,
                  rand_mask(int'($urandom % 3)), rand_mask(int'($urandom % 3)),
                  $urandom & 32'hFFFF_FFFC, 1'($urandom % 2),
                  1'(($urandom % 8) == 0), "R6");
         if (($urandom % 16) == 0) idle_check("R11");
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
   end

endmodule